// File: doc/BRIEF.md
# Prescaled Sequencer Counter

This block is a 24-bit up-counter used as a sequencer. It counts by one on every clock. When the count equals a programmable terminal value, the next clock either sends it back to zero or to a programmable start value, depending on a mode input. A one-clock wrap pulse marks every such return. A load strobe writes any value into the count. The cycle after a load is a settle cycle: the counter holds its value for that cycle and then resumes counting.

To keep the terminal decision short, the count has two parts. A 2-bit prescaler advances on every clock. A 22-bit upper part advances only when the prescaler rolls over. A register holds the result of comparing the upper part against its target minus one, so the result is ready one prescaler period early. An armed flag follows from that register. At full rate, only the 2 low bits are compared, and only while the flag is armed.

The terminal value, start value and mode may change only in a cycle where the load strobe is high, or during reset. The counter then rebuilds its internal match state during the settle cycle.

Top module: `presc_seq_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0 and `wrap_o` becomes 0. In the first cycle after `rst` falls, the count stays at 0 (settle cycle). It reaches 1 one clock later.
- R2: Outside terminal events, loads and settle cycles, the count rises by one per clock. It rolls over from 0xFFFFFF to 0 without a wrap pulse.
- R3: With `mode_reload_i` = 0 and a legal terminal value, a count equal to `term_i` is followed on the next clock by a count of 0.
- R4: With `mode_reload_i` = 1 and a legal terminal value, a count equal to `term_i` is followed on the next clock by a count equal to `reload_i`.
- R5: `wrap_o` is high for exactly one clock, in the cycle in which the count first shows the value it returned to.
- R6: A clock edge with `load_i` high puts `load_val_i` into the count. The count then holds that value for one more clock before counting resumes. No wrap pulse follows a load.
- R7: When `load_i` is high in a cycle where the count equals a legal terminal value, the load wins. The count takes `load_val_i` and `wrap_o` stays low.
- R8: A terminal value is legal only if it is at least 3 in clear mode, or at least `reload_i` + 3 in reload mode. An illegal terminal value causes no terminal event, and the count runs through the full 24-bit range.
- R9: The terminal event is detected whatever the positions of the start value and terminal value relative to 4-count boundaries. This includes a start value whose low bits are 3, and a loaded value equal to the terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| term_i | input | 24 | Terminal count value |
| reload_i | input | 24 | Start value used in reload mode |
| mode_reload_i | input | 1 | 0: return to zero; 1: return to `reload_i` |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 24 | Value written by the load strobe |
| count_o | output | 24 | Current count |
| wrap_o | output | 1 | One-clock pulse after a terminal event |

## Verification
A load strobe and a terminal event can fall in the same cycle. Both a wrap and a load want to write the count at that edge. The bench provokes this collision on purpose: it watches its reference count reach the terminal value and raises the strobe in exactly that cycle. Random loads also hit the same cycle by chance. The outcome counts as correct only if the count shows the load value, `wrap_o` stays low, and the following settle cycle holds that value.

// File: rtl/presc_seq_counter.sv
module presc_seq_counter #(
  parameter int W  = 24,
  parameter int PW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] term_i,
  input  logic [W-1:0] reload_i,
  input  logic         mode_reload_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  localparam int HW = W - PW;
  localparam logic [PW-1:0] LO_ONE = PW'(1);
  localparam logic [HW-1:0] HI_ONE = HW'(1);
  localparam logic [W:0]    GAP    = (W+1)'((2**PW) - 1);

  logic [PW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic stall_q, armed_q, near_q, wrap_q;
  logic legal_q, st_eq_q, st_near_q;

  wire [W-1:0]  start_v = mode_reload_i ? reload_i : '0;
  wire [HW-1:0] t_hi    = term_i[W-1:PW];
  wire [PW-1:0] t_lo    = term_i[PW-1:0];
  wire [HW-1:0] t_hi_m1 = t_hi - HI_ONE;
  wire [W:0]    min_term = {1'b0, start_v} + GAP;
  wire          lo_top  = &lo_q;
  wire          hit     = armed_q & legal_q & ~stall_q & (lo_q == t_lo);

  assign count_o = {hi_q, lo_q};
  assign wrap_o  = wrap_q;

  // configuration-derived flags, one register stage off the count path
  always_ff @(posedge clk) begin
    if (rst) begin
      legal_q   <= 1'b0;
      st_eq_q   <= 1'b0;
      st_near_q <= 1'b0;
    end else begin
      legal_q   <= {1'b0, term_i} >= min_term;
      st_eq_q   <= start_v[W-1:PW] == t_hi;
      st_near_q <= start_v[W-1:PW] == t_hi_m1;
    end
  end

  // predictive upper compare: upper part one step below its target
  always_ff @(posedge clk) begin
    if (!rst && !load_i && !stall_q && hit) near_q <= st_near_q;
    else                                    near_q <= (hi_q == t_hi_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      stall_q <= 1'b1;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else if (load_i) begin
      {hi_q, lo_q} <= load_val_i;
      stall_q <= 1'b1;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else if (stall_q) begin
      stall_q <= 1'b0;
      armed_q <= (hi_q == t_hi);
      wrap_q  <= 1'b0;
    end else if (hit) begin
      {hi_q, lo_q} <= start_v;
      armed_q <= st_eq_q;
      wrap_q  <= 1'b1;
    end else begin
      wrap_q <= 1'b0;
      lo_q   <= lo_q + LO_ONE;
      if (lo_top) begin
        hi_q    <= hi_q + HI_ONE;
        armed_q <= near_q;
      end
    end
  end

  assert_wrap_value_R3_R4: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !$past(rst)) |-> count_o == $past(start_v));

  assert_wrap_single_R5: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

  assert_load_takes_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(load_i) && !$past(rst)) |-> (count_o == $past(load_val_i) && !wrap_o));

  assert_settle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i) && $past(stall_q)) |-> $stable(count_o));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i) && !$past(stall_q) && !wrap_o)
      |-> count_o == $past(count_o) + W'(1));

  assert_armed_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !load_i) |-> hi_q == t_hi);
endmodule

// File: tb/test_presc_seq_counter.sv
module test_presc_seq_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, mode = 1'b0, load = 1'b0;
  logic [23:0] term = 24'd3, reload = '0, load_val = '0;
  logic [23:0] count;
  logic wrap;

  presc_seq_counter i_presc_seq_counter (
    .clk(clk), .rst(rst), .term_i(term), .reload_i(reload),
    .mode_reload_i(mode), .load_i(load), .load_val_i(load_val),
    .count_o(count), .wrap_o(wrap));

  int n_chk = 0, n_fail = 0;
  logic [23:0] r_cnt = '0;
  logic r_stall = 1'b1, r_wrap = 1'b0;

  function automatic bit legal_f(logic [23:0] t, logic [23:0] rl, logic m);
    return m ? ({1'b0, t} >= {1'b0, rl} + 25'd3) : (t >= 24'd3);
  endfunction

  task automatic check(string tg, logic [23:0] got, logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tg, got, exp, $time);
    end
  endtask

  task automatic tick(string tg);
    string t;
    @(posedge clk);
    if (rst)        begin r_cnt = '0; r_stall = 1'b1; r_wrap = 1'b0; end
    else if (load)  begin r_cnt = load_val; r_stall = 1'b1; r_wrap = 1'b0; end
    else if (r_stall) begin r_stall = 1'b0; r_wrap = 1'b0; end
    else if (legal_f(term, reload, mode) && r_cnt == term) begin
      r_cnt = mode ? reload : 24'd0; r_wrap = 1'b1;
    end else begin r_cnt = r_cnt + 24'd1; r_wrap = 1'b0; end
    @(negedge clk);
    t = tg;
    if (t == "") t = r_wrap ? (mode ? "R4" : "R3") : (r_stall ? "R6" : "R2");
    check(t, count, r_cnt);
    check({t, "/R5 wrap"}, {23'd0, wrap}, {23'd0, r_wrap});
  endtask

  task automatic do_load(logic m, logic [23:0] t, logic [23:0] rl, logic [23:0] v, string tg);
    mode = m; term = t; reload = rl; load_val = v; load = 1'b1;
    tick(tg);
    load = 1'b0;
  endtask

  task automatic run(int n, string tg);
    for (int i = 0; i < n; i++) tick(tg);
  endtask

  task automatic rand_load();
    logic m; logic [23:0] t, rl, v;
    m = 1'($urandom % 2);
    if (m) begin
      rl = 24'($urandom % 24'hFFFF00);
      if ($urandom % 8 == 0) begin t = rl + 24'($urandom % 3); v = rl; end
      else begin
        t = rl + 24'd3 + 24'($urandom % 60);
        v = rl + 24'($urandom % (32'(t - rl) + 1));
      end
    end else begin
      rl = 24'($urandom);
      if ($urandom % 8 == 0) begin t = 24'($urandom % 3); v = '0; end
      else begin
        t = ($urandom % 4 == 0) ? 24'd3 + 24'($urandom % 40) : 24'd3 + 24'($urandom % 24'hFFFFF0);
        v = (t > 24'd50) ? t - 24'($urandom % 50) : 24'($urandom % (32'(t) + 1));
      end
    end
    do_load(m, t, rl, v, "R6");
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    run(2, "R1");
    rst = 1'b0;
    tick("R1");                       // settle cycle holds 0
    tick("R2");                       // then 1
    // R3 shortest legal clear cycle
    do_load(1'b0, 24'd3, 24'd0, 24'd0, "R6");
    run(14, "");
    // R4 reload across a 4-count boundary
    do_load(1'b1, 24'h000205, 24'h0001FE, 24'h0001FE, "R6");
    run(24, "");
    // R9 start value with low bits 3, and load equal to terminal value
    do_load(1'b1, 24'h000106, 24'h000103, 24'h000106, "R9");
    run(14, "R9");
    do_load(1'b0, 24'h400003, 24'd0, 24'h400000, "R9");
    run(8, "R9");
    // R7 load in the cycle the terminal value is shown
    do_load(1'b1, 24'h00A013, 24'h00A00D, 24'h00A00D, "R6");
    while (!(r_cnt == term && !r_stall)) tick("");
    load = 1'b1; load_val = 24'h000123;
    tick("R7");
    load = 1'b0;
    run(4, "R7");
    // R8 illegal terminal values
    do_load(1'b0, 24'd2, 24'd0, 24'd0, "R8");
    run(12, "R8");
    do_load(1'b1, 24'h000101, 24'h000100, 24'h000100, "R8");
    run(12, "R8");
    do_load(1'b0, 24'd1, 24'd0, 24'hFFFFFC, "R2");
    run(10, "R2");                    // rollover to 0 without wrap
    // constrained random
    for (int i = 0; i < 15000; i++) begin
      if ($urandom % 60 == 0) rand_load();
      else tick("");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule